// File: doc/BRIEF.md
# Timer Compare-Output Waveform Unit

This block is a 16-bit up-counting timer with three compare channels. On every enabled count tick the counter steps by one. The counter returns to zero at a TOP value, and the waveform mode field chooses that TOP value. Each channel compares the count with its own compare register. It then changes its output flip-flop according to a 2-bit output code. The same code means different things in the non-PWM timer behaviours and in fast PWM.

Beside each pin level the block drives a "connected" flag. The flag tells the pad logic whether the timer owns the pin or the general-purpose port keeps it. A change to a mode field or an output code is only acted on at count ticks. The pins therefore never move between ticks.

Top module: `tmr_wave_unit`

## Requirements
- R1: While `rstN` is low the counter is zero and all three pin levels are low. After reset, with every output code at 00, all connected flags are low.
- R2: The counter advances and the pins change only on a clock edge where `tickEn` is high. When `tickEn` is low the pin levels hold.
- R3: Waveform mode 4 is CTC with TOP equal to compare register A. Mode 14 is fast PWM with TOP from `topReg`. Mode 15 is fast PWM with TOP equal to compare register A. Every other mode value is normal mode with TOP 0xFFFF. A tick taken while the count equals TOP reloads the counter to zero; any other tick adds one.
- R4: In a non-PWM mode, output code 00 leaves the channel's flip-flop unchanged and drives its connected flag low.
- R5: In a non-PWM mode, a tick taken while the count equals the channel's compare value acts on the flip-flop by output code: 01 inverts it, 10 drives it low, 11 drives it high. The new level is visible after that clock edge.
- R6: In fast PWM with output code 10, a tick at TOP drives the output high. Otherwise a tick at a compare match drives it low.
- R7: In fast PWM with output code 11, a tick at TOP drives the output low. Otherwise a tick at a compare match drives it high.
- R8: In fast PWM with output code 01, channel A inverts on a compare match and is connected. Channels B and C with code 01 are disconnected and hold their level.
- R9: In fast PWM, when a channel's compare value equals TOP and its code is 10 or 11, only the TOP action is applied; the match action is dropped.
- R10: A channel's connected flag is high exactly when its code is non-zero. The exception is code 01 on channel B or C in fast PWM, which is low. The flag follows the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Count enable from the prescaler |
| wgMode | input | 4 | Waveform mode (0 normal, 4 CTC, 14/15 fast PWM) |
| comA | input | 2 | Output code, channel A |
| comB | input | 2 | Output code, channel B |
| comC | input | 2 | Output code, channel C |
| cmpA | input | 16 | Compare value A (also TOP in modes 4 and 15) |
| cmpB | input | 16 | Compare value B |
| cmpC | input | 16 | Compare value C |
| topReg | input | 16 | TOP value for mode 14 |
| pinLevel | output | 3 | Output flip-flop levels, bit 0 = A, 1 = B, 2 = C |
| pinConnected | output | 3 | Timer owns the pin, same bit order |

## Verification
The bench targets a compare value equal to TOP under codes 10 and 11 in fast PWM. A design that let the match win would leave the output pulsing or stuck at the wrong level. It drives code 01 on all three channels in both fast PWM modes. A design that missed the channel-A exception would toggle or connect B and C. It gates `tickEn` irregularly, because a design that acted on matches without the enable would shift every edge. It also lets normal mode run through the full 0xFFFF wrap. A wrong reload point would misplace the second toggle by many cycles.

// File: rtl/tmr_wave_pkg.sv
package tmr_wave_pkg;
  localparam int NUM_CH = 3;

  typedef enum logic [1:0] {
    COM_OFF = 2'b00,
    COM_TGL = 2'b01,
    COM_CLR = 2'b10,
    COM_SET = 2'b11
  } comCode_e;

  localparam logic [3:0] WGM_CTC        = 4'd4;
  localparam logic [3:0] WGM_PWM_TOPREG = 4'd14;
  localparam logic [3:0] WGM_PWM_TOPA   = 4'd15;

  typedef struct packed {
    logic              reload;
    logic [NUM_CH-1:0] doSet;
    logic [NUM_CH-1:0] doClr;
    logic [NUM_CH-1:0] doTgl;
  } waveStrb_t;
endpackage

// File: rtl/tmr_wave_ctrl.sv
module tmr_wave_ctrl
  import tmr_wave_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                           tickEn,
  input  logic [3:0]                     wgMode,
  input  logic [NUM_CH-1:0][1:0]         comCodes,
  input  logic [CNT_W-1:0]               cmpFirst,
  input  logic [CNT_W-1:0]               topReg,
  input  logic                           eqTop,
  input  logic [NUM_CH-1:0]              eqCmp,
  output logic [CNT_W-1:0]               topVal,
  output waveStrb_t                      strb,
  output logic [NUM_CH-1:0]              connected
);
  logic isPwm;

  always_comb begin
    isPwm = (wgMode == WGM_PWM_TOPREG) || (wgMode == WGM_PWM_TOPA);
    case (wgMode)
      WGM_CTC, WGM_PWM_TOPA: topVal = cmpFirst;
      WGM_PWM_TOPREG:        topVal = topReg;
      default:               topVal = '1;
    endcase
  end

  assign strb.reload = tickEn && eqTop;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    comCode_e code;
    assign code = comCode_e'(comCodes[ch]);

    always_comb begin
      strb.doSet[ch] = 1'b0;
      strb.doClr[ch] = 1'b0;
      strb.doTgl[ch] = 1'b0;
      if (tickEn) begin
        if (!isPwm) begin
          case (code)
            COM_TGL: strb.doTgl[ch] = eqCmp[ch];
            COM_CLR: strb.doClr[ch] = eqCmp[ch];
            COM_SET: strb.doSet[ch] = eqCmp[ch];
            default: ;
          endcase
        end else begin
          case (code)
            COM_CLR: begin
              strb.doSet[ch] = eqTop;
              strb.doClr[ch] = !eqTop && eqCmp[ch];
            end
            COM_SET: begin
              strb.doClr[ch] = eqTop;
              strb.doSet[ch] = !eqTop && eqCmp[ch];
            end
            COM_TGL: strb.doTgl[ch] = (ch == 0) && eqCmp[ch];
            default: ;
          endcase
        end
      end
    end

    assign connected[ch] = (code != COM_OFF) &&
                           !(isPwm && code == COM_TGL && ch != 0);
  end
endmodule

// File: rtl/tmr_wave_dp.sv
module tmr_wave_dp
  import tmr_wave_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           tickEn,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   cmpVals,
  input  logic [CNT_W-1:0]               topVal,
  input  waveStrb_t                      strb,
  output logic                           eqTop,
  output logic [NUM_CH-1:0]              eqCmp,
  output logic [CNT_W-1:0]               cntVal,
  output logic [NUM_CH-1:0]              outLevel
);
  assign eqTop = (cntVal == topVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntVal <= '0;
    else if (strb.reload) cntVal <= '0;
    else if (tickEn)      cntVal <= cntVal + 1'b1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_out
    assign eqCmp[ch] = (cntVal == cmpVals[ch]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 outLevel[ch] <= 1'b0;
      else if (strb.doSet[ch])   outLevel[ch] <= 1'b1;
      else if (strb.doClr[ch])   outLevel[ch] <= 1'b0;
      else if (strb.doTgl[ch])   outLevel[ch] <= ~outLevel[ch];
    end
  end
endmodule

// File: rtl/tmr_wave_unit.sv
module tmr_wave_unit
  import tmr_wave_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic [3:0]       wgMode,
  input  logic [1:0]       comA,
  input  logic [1:0]       comB,
  input  logic [1:0]       comC,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  input  logic [CNT_W-1:0] cmpC,
  input  logic [CNT_W-1:0] topReg,
  output logic [2:0]       pinLevel,
  output logic [2:0]       pinConnected
);
  logic [NUM_CH-1:0][1:0]       comCodes;
  logic [NUM_CH-1:0][CNT_W-1:0] cmpVals;
  logic [CNT_W-1:0]             topVal;
  logic [CNT_W-1:0]             cntVal;
  logic                         eqTop;
  logic [NUM_CH-1:0]            eqCmp;
  waveStrb_t                    strb;

  assign comCodes = {comC, comB, comA};
  assign cmpVals  = {cmpC, cmpB, cmpA};

  tmr_wave_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .tickEn   (tickEn),
    .wgMode   (wgMode),
    .comCodes (comCodes),
    .cmpFirst (cmpA),
    .topReg   (topReg),
    .eqTop    (eqTop),
    .eqCmp    (eqCmp),
    .topVal   (topVal),
    .strb     (strb),
    .connected(pinConnected)
  );

  tmr_wave_dp #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .cmpVals (cmpVals),
    .topVal  (topVal),
    .strb    (strb),
    .eqTop   (eqTop),
    .eqCmp   (eqCmp),
    .cntVal  (cntVal),
    .outLevel(pinLevel)
  );
endmodule

// File: rtl/tmr_wave_chk.sv
module tmr_wave_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic [3:0]       wgMode,
  input logic [1:0]       comA,
  input logic [1:0]       comB,
  input logic [1:0]       comC,
  input logic [CNT_W-1:0] cmpA,
  input logic [CNT_W-1:0] cmpB,
  input logic [CNT_W-1:0] topReg,
  input logic [CNT_W-1:0] cntVal,
  input logic [2:0]       pinLevel,
  input logic [2:0]       pinConnected
);
  logic pwmNow;
  assign pwmNow = (wgMode == 4'd14) || (wgMode == 4'd15);

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(pinLevel)); // R2

  AST_CTC_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wgMode == 4'd4 && tickEn && cntVal == cmpA) |=> (cntVal == '0)); // R3

  AST_NORMAL_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (wgMode == 4'd0 && tickEn && cntVal == '1) |=> (cntVal == '0)); // R3

  AST_OFF_DISCONNECT: assert property (@(posedge clk) disable iff (!rstN)
    (comA == 2'b00) |-> !pinConnected[0]); // R4

  AST_NP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wgMode == 4'd4 && tickEn && comB == 2'b10 && cntVal == cmpB) |=> !pinLevel[1]); // R5

  AST_PWM_TOP_SET: assert property (@(posedge clk) disable iff (!rstN)
    (wgMode == 4'd14 && tickEn && comC == 2'b10 && cntVal == topReg) |=> pinLevel[2]); // R6

  AST_PWM_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (wgMode == 4'd14 && tickEn && comB == 2'b11 && cntVal == topReg) |=> !pinLevel[1]); // R7

  AST_PWM_TGL_B_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (pwmNow && comB == 2'b01) |-> !pinConnected[1]); // R8
endmodule

bind tmr_wave_unit tmr_wave_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .tickEn      (tickEn),
  .wgMode      (wgMode),
  .comA        (comA),
  .comB        (comB),
  .comC        (comC),
  .cmpA        (cmpA),
  .cmpB        (cmpB),
  .topReg      (topReg),
  .cntVal      (cntVal),
  .pinLevel    (pinLevel),
  .pinConnected(pinConnected)
);

// File: tb/test_tmr_wave_unit.sv
module test_tmr_wave_unit;
  localparam int CLK_P     = 10;
  localparam int WDOG_LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rstN;
  logic        tickEn;
  logic [3:0]  wgMode;
  logic [1:0]  comA, comB, comC;
  logic [15:0] cmpA, cmpB, cmpC, topReg;
  logic [2:0]  pinLevel, pinConnected;

  int    checks = 0;
  int    fails = 0;
  int    cycles = 0;
  bit    done = 0;
  string phaseTag = "R1";
  int    mCnt = 0;
  bit    mPin [3] = '{0, 0, 0};

  always #(CLK_P/2) clk = ~clk;

  tmr_wave_unit i_tmr_wave_unit (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wgMode(wgMode),
    .comA(comA), .comB(comB), .comC(comC),
    .cmpA(cmpA), .cmpB(cmpB), .cmpC(cmpC), .topReg(topReg),
    .pinLevel(pinLevel), .pinConnected(pinConnected)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int topOf();
    case (wgMode)
      4'd4:    return int'(cmpA);
      4'd14:   return int'(topReg);
      4'd15:   return int'(cmpA);
      default: return 65535;
    endcase
  endfunction

  // behavioural reference, stepped on every rising edge, compared a quarter period later
  always @(posedge clk) begin
    int  t, cm [3];
    bit  pwm, eq, atT;
    int  cd [3];
    cycles++;
    cm = '{int'(cmpA), int'(cmpB), int'(cmpC)};
    cd = '{int'(comA), int'(comB), int'(comC)};
    pwm = (wgMode == 4'd14) || (wgMode == 4'd15);
    if (!rstN) begin
      mCnt = 0;
      mPin = '{0, 0, 0};
    end else if (tickEn) begin
      t = topOf();
      atT = (mCnt == t);
      for (int ch = 0; ch < 3; ch++) begin
        eq = (mCnt == cm[ch]);
        if (!pwm) begin
          if (eq && cd[ch] == 1) mPin[ch] = !mPin[ch];
          if (eq && cd[ch] == 2) mPin[ch] = 0;
          if (eq && cd[ch] == 3) mPin[ch] = 1;
        end else begin
          if (cd[ch] == 2) begin
            if (atT) mPin[ch] = 1; else if (eq) mPin[ch] = 0;
          end else if (cd[ch] == 3) begin
            if (atT) mPin[ch] = 0; else if (eq) mPin[ch] = 1;
          end else if (cd[ch] == 1 && ch == 0 && eq) begin
            mPin[ch] = !mPin[ch];
          end
        end
      end
      mCnt = atT ? 0 : (mCnt + 1) % 65536;
    end
    #(CLK_P/4);
    if (!done) begin
      cd = '{int'(comA), int'(comB), int'(comC)};
      pwm = (wgMode == 4'd14) || (wgMode == 4'd15);
      for (int ch = 0; ch < 3; ch++) begin
        check(phaseTag, $sformatf("pinLevel[%0d]", ch), int'(pinLevel[ch]), int'(mPin[ch]));
        check(phaseTag, $sformatf("pinConnected[%0d] (R10)", ch), int'(pinConnected[ch]),
              int'(cd[ch] != 0 && !(pwm && cd[ch] == 1 && ch != 0)));
      end
    end
    if (cycles > WDOG_LIMIT && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rstN = 0; tickEn = 0; wgMode = 0;
    comA = 0; comB = 0; comC = 0;
    cmpA = 0; cmpB = 0; cmpC = 0; topReg = 0;
    run(3);
    check("R1", "pinLevel in reset", int'(pinLevel), 0);
    check("R1", "pinConnected in reset", int'(pinConnected), 0);
    rstN = 1; tickEn = 1;
    run(4);
    check("R1", "pinLevel after reset, codes 00", int'(pinLevel), 0);

    // R2: irregular enable in CTC with toggle on A
    phaseTag = "R2";
    wgMode = 4'd4; cmpA = 16'd5; comA = 2'b01;
    for (int i = 0; i < 40; i++) begin
      tickEn = (i % 3 != 0);
      @(negedge clk);
    end
    tickEn = 1;

    // R5: non-PWM toggle / clear / set
    phaseTag = "R5";
    cmpA = 16'd9; comB = 2'b10; cmpB = 16'd3; comC = 2'b11; cmpC = 16'd6;
    run(40);

    // R4: code 00 holds the flip-flop and disconnects
    phaseTag = "R4";
    comB = 2'b00; comC = 2'b00;
    run(25);

    // R6 / R7: fast PWM with TOP from topReg
    phaseTag = "R6";
    wgMode = 4'd14; topReg = 16'd20;
    comA = 2'b10; cmpA = 16'd7; comC = 2'b10; cmpC = 16'd0;
    comB = 2'b11; cmpB = 16'd12;
    run(50);
    phaseTag = "R7";
    run(50);

    // R9: compare value equal to TOP
    phaseTag = "R9";
    cmpB = 16'd20; comB = 2'b10; cmpC = 16'd20; comC = 2'b11;
    run(50);

    // R8: code 01 in both fast PWM modes
    phaseTag = "R8";
    wgMode = 4'd15; cmpA = 16'd10; comA = 2'b01; comB = 2'b01; comC = 2'b01;
    cmpB = 16'd4; cmpC = 16'd2;
    run(40);
    wgMode = 4'd14; cmpA = 16'd3;
    run(40);

    // R10: same code 01 in a non-PWM mode connects every channel
    phaseTag = "R10";
    wgMode = 4'd4; cmpA = 16'd8;
    run(20);

    // R3: mode 15 TOP from cmpA, then a full normal-mode wrap
    phaseTag = "R3";
    wgMode = 4'd15; cmpA = 16'd6; comA = 2'b10; comB = 2'b00; comC = 2'b00;
    run(30);
    wgMode = 4'd0; comA = 2'b01; cmpA = 16'd3;
    run(66000);

    done = 1;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule